// File: doc/BRIEF.md
# Dual-Clock FIFO with Arbitrary Capacity

This block moves data words from a producer clock domain to a consumer clock domain that has no fixed phase or frequency relation to it. The usable depth is a parameter that need not be a power of two. For example, the default holds six words. Software never sees the block. A producer writes when the `full` flag is low, and a consumer takes the head word from `rd_data` and pops it when `empty` is low.

Each side keeps its own pointer in two forms. The binary form addresses the storage and feeds the occupancy arithmetic. A registered reflected-binary (gray) copy is the only form that crosses to the other domain, through a two-stage synchronizer. The receiver turns it back into binary with a prefix-XOR scan.

The pointers always run over a power-of-two range, one bit wider than the storage address. As a result, every step changes one gray bit, including the rollover to zero. The smaller capacity limit is applied only where the write side compares the pointer difference against the parameter. The storage address is the low part of the pointer, and the storage depth is the next power of two at or above the capacity.

Top module: `xclk_fifo`

## Requirements
- R1: While either reset is asserted (low), and immediately after both are released, `empty` is 1 and `full` is 0.
- R2: Words come out on the read side in the order they were accepted, each exactly once, across many pointer wraps.
- R3: The write side accepts at most CAPACITY words beyond those it has seen read. `full` is 1 once CAPACITY words are held and no read has yet reached the write domain.
- R4: A write attempted while `full` is 1 is ignored: no word is stored and the write pointer does not move.
- R5: A read attempted while `empty` is 1 is ignored: the read pointer does not move, and the first word written later is still the first word read.
- R6: The gray write and read pointers change by at most one bit per edge of their own clock, including the wrap from the top of the range back to zero.
- R7: On every edge, each registered gray pointer equals `b ^ (b >> 1)` of the binary pointer it travels with.
- R8: The flags release with bounded lag. `empty` falls no more than three read-clock edges after a write is accepted, and `full` falls within five write-clock edges after a read. Neither flag is ever late to assert: `empty` rises on the same read edge that pops the last word seen.
- R9: `empty` is never 0 when no unread word exists.
- R10: While `empty` is 0, `rd_data` already shows the oldest unread word, before any read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer reset, asynchronous assert, active low |
| wr_en | input | 1 | Write request, taken when `full` is 0 |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room for another word |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer reset, asynchronous assert, active low |
| rd_en | input | 1 | Pop request, taken when `empty` is 0 |
| rd_data | output | DATA_W | Oldest unread word |
| empty | output | 1 | No unread word visible |

## Verification
The bound checker watches the pointer discipline on every edge of each clock. It checks that each gray pointer moves at most one bit (R6) and tracks its binary partner (R7), that each pointer advances exactly on an accepted request and holds on a refused one (R4, R5), and that the write-side occupancy never goes past the capacity (R3). Ordering, loss and duplication (R2), the flag latencies (R8), the conservative `empty` (R9) and the head-word presentation (R10) involve both clocks and the stored data. Only the bench scenarios can show these: directed fill-to-full, read-while-empty and drain sequences, followed by long random traffic on unrelated clocks that drives the pointers through many wraps.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  typedef logic [31:0] word_t;

  function automatic word_t to_gray(input word_t b);
    return b ^ (b >> 1);
  endfunction

  // prefix-XOR scan: top bit passes, each lower bit folds in all bits above
  function automatic word_t from_gray(input word_t g);
    word_t b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xclk_fifo_ptr.sv
module xclk_fifo_ptr
  import xclk_fifo_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] gray_q
);

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] bin_nxt;
  logic [PW-1:0] gray_nxt;
  word_t         gray_w;

  always_comb begin
    bin_nxt  = step ? (bin_q + ONE) : bin_q;
    gray_w   = to_gray(word_t'(bin_nxt));
    gray_nxt = gray_w[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (step) begin
      bin_q  <= bin_nxt;
      gray_q <= gray_nxt;
    end
  end

endmodule

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_nxt;

  always_comb begin
    stage_nxt[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stage_nxt[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xclk_fifo_store.sv
module xclk_fifo_store #(
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int DEPTH = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0]    cell_q [DEPTH];
  logic [DEPTH-1:0] cell_we;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
    assign cell_we[gi] = we && (waddr == AW'(gi));
  end

  always_ff @(posedge wclk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (cell_we[i]) begin
        cell_q[i] <= wdata;
      end
    end
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CAPACITY = 6
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);

  localparam int            AW    = (CAPACITY > 1) ? $clog2(CAPACITY) : 1;
  localparam int            DEPTH = 1 << AW;
  localparam int            PW    = AW + 1;
  localparam logic [PW-1:0] CAP_P = PW'(CAPACITY);

  // write domain
  logic [PW-1:0] wr_bin, wr_gray;
  logic [PW-1:0] rd_gray_s, rd_bin_s;
  logic [PW-1:0] wr_occ;
  logic          wr_go;
  word_t         rd_scan;

  // read domain
  logic [PW-1:0] rd_bin, rd_gray;
  logic [PW-1:0] wr_gray_s, wr_bin_s;
  logic          rd_go;
  word_t         wr_scan;

  assign wr_go = wr_en && !full;
  assign rd_go = rd_en && !empty;

  xclk_fifo_ptr #(.PW(PW)) u_wptr (
    .clk    (wr_clk),
    .rst_n  (wr_rst_n),
    .step   (wr_go),
    .bin_q  (wr_bin),
    .gray_q (wr_gray)
  );

  xclk_fifo_ptr #(.PW(PW)) u_rptr (
    .clk    (rd_clk),
    .rst_n  (rd_rst_n),
    .step   (rd_go),
    .bin_q  (rd_bin),
    .gray_q (rd_gray)
  );

  xclk_fifo_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_gray),
    .q     (rd_gray_s)
  );

  xclk_fifo_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_gray),
    .q     (wr_gray_s)
  );

  always_comb begin
    rd_scan  = from_gray(word_t'(rd_gray_s));
    rd_bin_s = rd_scan[PW-1:0];
    wr_occ   = wr_bin - rd_bin_s;
    full     = (wr_occ == CAP_P);
  end

  always_comb begin
    wr_scan  = from_gray(word_t'(wr_gray_s));
    wr_bin_s = wr_scan[PW-1:0];
    empty    = (wr_bin_s == rd_bin);
  end

  xclk_fifo_store #(.DW(DATA_W), .AW(AW), .DEPTH(DEPTH)) u_store (
    .wclk  (wr_clk),
    .we    (wr_go),
    .waddr (wr_bin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_bin[AW-1:0]),
    .rdata (rd_data)
  );

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int PW       = 4,
  parameter int CAPACITY = 6
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_en,
  input logic          full,
  input logic [PW-1:0] wr_bin,
  input logic [PW-1:0] wr_gray,
  input logic [PW-1:0] wr_occ,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_en,
  input logic          empty,
  input logic [PW-1:0] rd_bin,
  input logic [PW-1:0] rd_gray
);

  localparam logic [PW-1:0] ONE = PW'(1);

  a_r6_wr_gray_one_bit: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  a_r6_rd_gray_one_bit: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  a_r7_wr_gray_tracks: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_gray == (wr_bin ^ (wr_bin >> 1)));

  a_r7_rd_gray_tracks: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_gray == (rd_bin ^ (rd_bin >> 1)));

  a_r3_occ_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_occ <= PW'(CAPACITY));

  a_r4_full_write_dropped: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && full) |=> $stable(wr_bin));

  a_r2_write_advances: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && !full) |=> (wr_bin == $past(wr_bin) + ONE));

  a_r5_empty_read_dropped: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && empty) |=> $stable(rd_bin));

  a_r2_read_advances: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !empty) |=> (rd_bin == $past(rd_bin) + ONE));

endmodule

bind xclk_fifo xclk_fifo_chk #(.PW(PW), .CAPACITY(CAPACITY)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .wr_en    (wr_en),
  .full     (full),
  .wr_bin   (wr_bin),
  .wr_gray  (wr_gray),
  .wr_occ   (wr_occ),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .rd_en    (rd_en),
  .empty    (empty),
  .rd_bin   (rd_bin),
  .rd_gray  (rd_gray)
);

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;

  localparam int DW  = 8;
  localparam int CAP = 6;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst_n, rd_rst_n;
  logic          wr_en, rd_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          full, empty;

  logic [DW-1:0] model_q[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            wr_done = 0;
  bit            finished = 0;

  xclk_fifo #(.DATA_W(DW), .CAPACITY(CAP)) u_xclk_fifo (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .full     (full),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .empty    (empty)
  );

  always #5 wr_clk = ~wr_clk;   // 100 MHz
  always #7 rd_clk = ~rd_clk;   // unrelated consumer clock

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pct(input int p);
    return (($urandom % 100) < p) ? 1 : 0;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    summary();
  end

  task automatic writer_run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic          en;
      logic [DW-1:0] d;
      en = pct((c < cycles / 2) ? 70 : 30) != 0;
      d  = DW'($urandom);
      if (en && !full) begin
        model_q.push_back(d);
        chk(model_q.size() <= CAP, "R3 occupancy", model_q.size(), CAP);
      end
      wr_en   = en;
      wr_data = d;
      @(posedge wr_clk); #1;
    end
    wr_en   = 1'b0;
    wr_done = 1;
  endtask

  task automatic reader_run();
    int c = 0;
    while (!(wr_done && model_q.size() == 0 && empty) && c < 60000) begin
      logic en;
      en = pct((c < 2500) ? 40 : 80) != 0;
      if (!empty) begin
        if (model_q.size() == 0) begin
          chk(0, "R9 empty low with nothing written", 0, 1);
        end else if (en) begin
          // ordered data across many wraps (R2, with R6/R7 pointer coding underneath)
          chk(rd_data == model_q[0], "R2 R6 R7 order", rd_data, model_q[0]);
          void'(model_q.pop_front());
        end
      end
      rd_en = en;
      @(posedge rd_clk); #1;
      c++;
    end
    rd_en = 1'b0;
  endtask

  initial begin
    int acc;
    int lat;
    void'($urandom(32'd20240611));
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    wr_data  = '0;

    repeat (3) @(posedge wr_clk);
    #1;
    chk(empty == 1'b1, "R1 empty in reset", empty, 1);
    chk(full == 1'b0, "R1 full in reset", full, 0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    @(posedge rd_clk); #1;
    chk(empty == 1'b1, "R1 empty after reset", empty, 1);
    chk(full == 1'b0, "R1 full after reset", full, 0);

    // reads while empty must be ignored
    rd_en = 1'b1;
    repeat (4) @(posedge rd_clk);
    #1;
    rd_en = 1'b0;
    chk(empty == 1'b1, "R5 still empty", empty, 1);

    @(posedge wr_clk); #1;
    wr_en   = 1'b1;
    wr_data = 8'h5A;
    model_q.push_back(8'h5A);
    @(posedge wr_clk); #1;
    wr_en = 1'b0;

    lat = 0;
    @(posedge rd_clk); #1;
    while (empty && lat < 8) begin
      @(posedge rd_clk); #1;
      lat++;
    end
    chk(!empty && lat <= 3, "R8 empty release lag", lat, 3);
    chk(rd_data == 8'h5A, "R5 R10 head word after ignored reads", rd_data, 8'h5A);
    rd_en = 1'b1;
    void'(model_q.pop_front());
    @(posedge rd_clk); #1;
    rd_en = 1'b0;
    chk(empty == 1'b1, "R8 R9 empty on last pop", empty, 1);

    // fill past capacity with no reads
    repeat (4) @(posedge wr_clk);
    #1;
    acc = 0;
    for (int i = 0; i < 10; i++) begin
      if (!full) begin
        acc++;
        model_q.push_back(DW'(8'hA0 + i));
      end
      wr_en   = 1'b1;
      wr_data = DW'(8'hA0 + i);
      @(posedge wr_clk); #1;
    end
    wr_en = 1'b0;
    chk(acc == CAP, "R3 accepted count", acc, CAP);
    chk(full == 1'b1, "R3 full at capacity", full, 1);

    repeat (4) @(posedge rd_clk);
    #1;
    for (int i = 0; i < CAP; i++) begin
      chk(!empty && rd_data == model_q[0], "R2 R10 drain order", rd_data, model_q[0]);
      rd_en = 1'b1;
      void'(model_q.pop_front());
      @(posedge rd_clk); #1;
    end
    rd_en = 1'b0;
    chk(empty == 1'b1, "R8 empty after drain", empty, 1);
    repeat (5) @(posedge wr_clk);
    #1;
    chk(full == 1'b0, "R8 full release lag", full, 0);
    repeat (5) @(posedge rd_clk);
    #1;
    chk(empty == 1'b1, "R4 refused writes not stored", empty, 1);

    // long random traffic, pointers wrap many times
    fork
      writer_run(4000);
      reader_run();
    join

    chk(model_q.size() == 0, "R2 nothing lost", model_q.size(), 0);
    chk(empty == 1'b1, "R9 empty at end", empty, 1);
    summary();
  end

endmodule